// File: doc/BRIEF.md
# Receive-Side Flow Character Filter

This block sits between a UART receiver and its receive FIFO. Each time the receiver completes a character, the block compares it with four programmed flow characters: two "stop" characters and two "go" characters. It decides whether the character goes into the FIFO. A matched stop request raises a level that tells the transmitter to pause once the character it is sending completes. A matched go request lowers that level again. The block can match a single character or a pair of characters received back to back. Only the low 5, 6, 7 or 8 bits take part in the compare, according to the active word length.

A fourth mode turns pause control off and watches for the second stop character as a marker. A matching marker character is still stored, and the status flag is raised. Characters that complete a flow request are never stored. In pair mode, when a first character is held back and its partner does not follow, the held character is released ahead of the new one, so no data is lost. For this reason the FIFO side has two write lanes, and lane 0 is always written before lane 1. All outputs change on the clock edge that samples the character strobe.

Top module: `flowchar_detect`

## Requirements
- R1: While reset is low at a clock edge, all outputs are driven to zero after that edge: both write lanes idle, pause level low, flag low and interrupt low.
- R2: In mode 2'b00 (off), every strobed character is presented on lane 0 (`fifo_wr_o` = 2'b01, `fifo_d0_o` = the character) one cycle after the strobe, and the pause level stays low.
- R3: Compares use only the low 5, 6, 7 or 8 bits for word-length codes 2'b00, 2'b01, 2'b10 and 2'b11. The upper bits of the character and of the compare values are ignored. A character that matches no compare value is stored on lane 0.
- R4: In mode 2'b01 (single), a character that equals the first stop value sets the pause level one cycle after its strobe and is not stored.
- R5: In mode 2'b01, a character that equals the first go value clears the pause level and is not stored. When a character equals both values, the stop match takes priority.
- R6: In mode 2'b10 (pair), the first stop value followed by the second stop value sets the pause level after the second character, and neither character is stored.
- R7: In mode 2'b10, the first go value followed by the second go value clears the pause level, and neither character is stored.
- R8: In mode 2'b10, when a held first character is followed by a character that neither completes its pair nor starts a new one, the held character is written on lane 0 and the new character on lane 1 in the same cycle.
- R9: In mode 2'b10, when a held first character is followed by another first value (stop or go), the held character alone is written on lane 0 and the new character becomes the held one.
- R10: A completed stop request sets the flag when `flag_en_i` is 1. A completed go request or `flag_clr_i` clears the flag, and a simultaneous set wins over `flag_clr_i`. The interrupt output equals the flag gated by `rx_irq_en_i`.
- R11: In mode 2'b11 (marker), a character that equals the second stop value is stored on lane 0 and sets the flag when `flag_en_i` is 1. The pause level is held low in this mode.
- R12: When the mode leaves 2'b01/2'b10, the pause level drops on the next edge, and a held character is written on lane 0 on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid_i | input | 1 | One-cycle strobe: a character is complete |
| rx_char_i | input | 8 | Received character, bit 0 received first |
| wlen_i | input | 2 | Word-length code, 5 + code bits compared |
| mode_i | input | 2 | 00 off, 01 single, 10 pair, 11 marker |
| flag_en_i | input | 1 | Allows matches to set the flag |
| rx_irq_en_i | input | 1 | Routes the flag to the interrupt |
| flag_clr_i | input | 1 | Clears the flag |
| xon1_i | input | 8 | First go value |
| xon2_i | input | 8 | Second go value |
| xoff1_i | input | 8 | First stop value (also single-mode stop) |
| xoff2_i | input | 8 | Second stop value (also marker value) |
| fifo_wr_o | output | 2 | Write strobes of lane 1 and lane 0 |
| fifo_d0_o | output | 8 | Lane 0 data, written first |
| fifo_d1_o | output | 8 | Lane 1 data, written second |
| tx_suspend_o | output | 1 | Transmitter pause level |
| flag_o | output | 1 | Match status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a broken pair in which a held character must be released while a new character arrives. The worst form of it is when that new character is itself a first value, so it replaces the held one instead of being stored. The bench holds the first stop value and then sweeps every possible second character. It follows each held case with a neutral character to flush the new hold, and it follows the completed stop case with a go pair. Word-length masking is reached by sweeping all 256 characters under each of the four length codes in single mode. The release on mode exit is reached by holding a character while paused and then switching the mode with no strobe.

// File: rtl/fcd_pkg.sv
// Package: shared types and constants of the flow character filter.
// Assumes compare values are packed in the order given by the REF_* indices.
package fcd_pkg;
    typedef enum logic [1:0] {
        FC_OFF     = 2'b00,
        FC_SINGLE  = 2'b01,
        FC_DOUBLE  = 2'b10,
        FC_SPECIAL = 2'b11
    } fc_mode_e;

    localparam int unsigned NREF     = 4;
    localparam int unsigned REF_ON1  = 0;
    localparam int unsigned REF_ON2  = 1;
    localparam int unsigned REF_OFF1 = 2;
    localparam int unsigned REF_OFF2 = 3;
endpackage

// File: rtl/fcd_cmp.sv
// Module: fcd_cmp
// Compares one character against every compare value, using only the low
// bits that the word-length code selects.
// Assumes the code counts upward from the shortest word, one bit per step.
module fcd_cmp #(
    parameter int unsigned CW   = 8,
    parameter int unsigned WLB  = 2,
    parameter int unsigned NREF = 4
) (
    input  logic [CW-1:0]            ch,
    input  logic [WLB-1:0]           wlen,
    input  logic [NREF-1:0][CW-1:0]  refs,
    output logic [NREF-1:0]          hit
);
    localparam int unsigned MINB = CW - (1 << WLB) + 1;

    logic [CW-1:0] keep;

    // Build the bit-keep mask from the word-length code.
    for (genvar b = 0; b < CW; b++) begin : g_keep
        if (b < MINB) begin : g_fixed
            assign keep[b] = 1'b1;
        end else begin : g_var
            assign keep[b] = ({1'b0, wlen} >= (WLB+1)'(b - MINB + 1));
        end
    end

    // One masked equality per compare value.
    for (genvar r = 0; r < NREF; r++) begin : g_hit
        assign hit[r] = (((ch ^ refs[r]) & keep) == '0);
    end
endmodule

// File: rtl/fcd_seq.sv
// Module: fcd_seq
// Tracks single and pair matches, holds a pending first character, and
// produces the two-lane FIFO write and the match events.
// Assumes at most one strobe per cycle; events are combinational and the
// FIFO lanes are registered, so both take effect at the same edge.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fc_mode_e         mode,
    input  logic             rx_valid,
    input  logic [CW-1:0]    rx_char,
    input  logic [NREF-1:0]  hit,
    output logic [1:0]       wr_en,
    output logic [CW-1:0]    wr_d0,
    output logic [CW-1:0]    wr_d1,
    output logic             ev_off,
    output logic             ev_on,
    output logic             ev_spec
);
    logic          hold_v,  nxt_hv;
    logic [CW-1:0] hold_d,  nxt_hd;
    logic          hold_off, nxt_ho;
    logic          hold_on,  nxt_hn;
    logic [1:0]    nxt_wr;
    logic [CW-1:0] nxt_d0, nxt_d1;
    logic          pass;

    // Decide events, hold updates and lane contents for this cycle.
    always_comb begin
        nxt_wr  = '0;
        nxt_d0  = '0;
        nxt_d1  = '0;
        nxt_hv  = hold_v;
        nxt_hd  = hold_d;
        nxt_ho  = hold_off;
        nxt_hn  = hold_on;
        ev_off  = 1'b0;
        ev_on   = 1'b0;
        ev_spec = 1'b0;
        pass    = 1'b0;
        if (mode == FC_DOUBLE) begin
            if (rx_valid) begin
                if (hold_v && hold_off && hit[REF_OFF2]) begin
                    ev_off = 1'b1;
                    nxt_hv = 1'b0;
                end else if (hold_v && hold_on && hit[REF_ON2]) begin
                    ev_on  = 1'b1;
                    nxt_hv = 1'b0;
                end else begin
                    if (hold_v) begin
                        nxt_wr[0] = 1'b1;
                        nxt_d0    = hold_d;
                    end
                    if (hit[REF_OFF1] || hit[REF_ON1]) begin
                        nxt_hv = 1'b1;
                        nxt_hd = rx_char;
                        nxt_ho = hit[REF_OFF1];
                        nxt_hn = hit[REF_ON1];
                    end else begin
                        nxt_hv = 1'b0;
                        if (hold_v) begin
                            nxt_wr[1] = 1'b1;
                            nxt_d1    = rx_char;
                        end else begin
                            nxt_wr[0] = 1'b1;
                            nxt_d0    = rx_char;
                        end
                    end
                end
            end
        end else begin
            if (hold_v) begin
                nxt_wr[0] = 1'b1;
                nxt_d0    = hold_d;
                nxt_hv    = 1'b0;
            end
            if (rx_valid) begin
                pass = 1'b1;
                if (mode == FC_SINGLE) begin
                    if (hit[REF_OFF1]) begin
                        ev_off = 1'b1;
                        pass   = 1'b0;
                    end else if (hit[REF_ON1]) begin
                        ev_on  = 1'b1;
                        pass   = 1'b0;
                    end
                end else if (mode == FC_SPECIAL) begin
                    ev_spec = hit[REF_OFF2];
                end
                if (pass) begin
                    if (hold_v) begin
                        nxt_wr[1] = 1'b1;
                        nxt_d1    = rx_char;
                    end else begin
                        nxt_wr[0] = 1'b1;
                        nxt_d0    = rx_char;
                    end
                end
            end
        end
    end

    // Register the hold slot and the FIFO lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_d   <= '0;
            hold_off <= 1'b0;
            hold_on  <= 1'b0;
            wr_en    <= '0;
            wr_d0    <= '0;
            wr_d1    <= '0;
        end else begin
            hold_v   <= nxt_hv;
            hold_d   <= nxt_hd;
            hold_off <= nxt_ho;
            hold_on  <= nxt_hn;
            wr_en    <= nxt_wr;
            wr_d0    <= nxt_d0;
            wr_d1    <= nxt_d1;
        end
    end
endmodule

// File: rtl/fcd_state.sv
// Module: fcd_state
// Holds the transmitter pause level and the match flag.
// Assumes the events are single-cycle pulses from fcd_seq.
module fcd_state
    import fcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  fc_mode_e mode,
    input  logic     ev_off,
    input  logic     ev_on,
    input  logic     ev_spec,
    input  logic     flag_en,
    input  logic     flag_clr,
    output logic     suspend,
    output logic     flag
);
    logic flow_on;

    assign flow_on = (mode == FC_SINGLE) || (mode == FC_DOUBLE);

    // Pause level: forced low outside the flow modes.
    always_ff @(posedge clk) begin
        if (!rst_n)          suspend <= 1'b0;
        else if (!flow_on)   suspend <= 1'b0;
        else if (ev_off)     suspend <= 1'b1;
        else if (ev_on)      suspend <= 1'b0;
    end

    // Flag: a set event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag <= 1'b0;
        else if ((ev_off || ev_spec) && flag_en) flag <= 1'b1;
        else if (ev_on || flag_clr)              flag <= 1'b0;
    end
endmodule

// File: rtl/flowchar_detect.sv
// Module: flowchar_detect (top)
// Filters received characters for flow-control requests and markers,
// drives the pause level, the flag and the interrupt.
// Assumes the strobe arrives at most once per cycle and the compare values
// are stable while characters are arriving.
module flowchar_detect
    import fcd_pkg::*;
#(
    parameter int unsigned CW  = 8,
    parameter int unsigned WLB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid_i,
    input  logic [CW-1:0] rx_char_i,
    input  logic [WLB-1:0] wlen_i,
    input  logic [1:0]    mode_i,
    input  logic          flag_en_i,
    input  logic          rx_irq_en_i,
    input  logic          flag_clr_i,
    input  logic [CW-1:0] xon1_i,
    input  logic [CW-1:0] xon2_i,
    input  logic [CW-1:0] xoff1_i,
    input  logic [CW-1:0] xoff2_i,
    output logic [1:0]    fifo_wr_o,
    output logic [CW-1:0] fifo_d0_o,
    output logic [CW-1:0] fifo_d1_o,
    output logic          tx_suspend_o,
    output logic          flag_o,
    output logic          irq_o
);
    fc_mode_e                mode;
    logic [NREF-1:0][CW-1:0] refs;
    logic [NREF-1:0]         hit;
    logic                    ev_off, ev_on, ev_spec;

    assign mode            = fc_mode_e'(mode_i);
    assign refs[REF_ON1]   = xon1_i;
    assign refs[REF_ON2]   = xon2_i;
    assign refs[REF_OFF1]  = xoff1_i;
    assign refs[REF_OFF2]  = xoff2_i;

    fcd_cmp #(.CW(CW), .WLB(WLB), .NREF(NREF)) cmp_i (
        .ch   (rx_char_i),
        .wlen (wlen_i),
        .refs (refs),
        .hit  (hit)
    );

    fcd_seq #(.CW(CW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .rx_valid (rx_valid_i),
        .rx_char  (rx_char_i),
        .hit      (hit),
        .wr_en    (fifo_wr_o),
        .wr_d0    (fifo_d0_o),
        .wr_d1    (fifo_d1_o),
        .ev_off   (ev_off),
        .ev_on    (ev_on),
        .ev_spec  (ev_spec)
    );

    fcd_state state_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .ev_off   (ev_off),
        .ev_on    (ev_on),
        .ev_spec  (ev_spec),
        .flag_en  (flag_en_i),
        .flag_clr (flag_clr_i),
        .suspend  (tx_suspend_o),
        .flag     (flag_o)
    );

    // Interrupt follows the flag when receive interrupts are enabled.
    assign irq_o = flag_o & rx_irq_en_i;
endmodule

// File: rtl/fcd_chk.sv
// Module: fcd_chk
// Port-level properties of flowchar_detect, attached by bind below.
module fcd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       rx_valid_i,
    input logic       flag_clr_i,
    input logic [1:0] fifo_wr_o,
    input logic       tx_suspend_o,
    input logic       flag_o
);
    // R8: lane 1 is never written without lane 0.
    a_r8_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o[1] |-> fifo_wr_o[0]);

    // R12: outside the flow modes the pause level is low on the next edge.
    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 || mode_i == 2'b11) |=> !tx_suspend_o);

    // R2: in off mode every strobed character reaches lane 0.
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && mode_i == 2'b00) |=> fifo_wr_o[0]);

    // R11: in marker mode every strobed character is stored.
    a_r11_marker_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && mode_i == 2'b11) |=> fifo_wr_o[0]);

    // R10: a clear with no character pending leaves the flag low.
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !rx_valid_i) |=> !flag_o);
endmodule

bind flowchar_detect fcd_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .rx_valid_i   (rx_valid_i),
    .flag_clr_i   (flag_clr_i),
    .fifo_wr_o    (fifo_wr_o),
    .tx_suspend_o (tx_suspend_o),
    .flag_o       (flag_o)
);

// File: tb/flowchar_detect_tb_top.sv
module flowchar_detect_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic [1:0] wlen = 2'b11;
    logic [1:0] mode = 2'b00;
    logic       flag_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h17, xoff1 = 8'h13, xoff2 = 8'h19;
    logic [1:0] fifo_wr;
    logic [7:0] d0, d1;
    logic       sus, flag, irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flowchar_detect dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_char_i(rx_char),
        .wlen_i(wlen), .mode_i(mode), .flag_en_i(flag_en), .rx_irq_en_i(irq_en),
        .flag_clr_i(flag_clr), .xon1_i(xon1), .xon2_i(xon2), .xoff1_i(xoff1),
        .xoff2_i(xoff2), .fifo_wr_o(fifo_wr), .fifo_d0_o(d0), .fifo_d1_o(d1),
        .tx_suspend_o(sus), .flag_o(flag), .irq_o(irq)
    );

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        rx_char  = c;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [1:0] ewr,
                              input logic [7:0] ed0, input logic [7:0] ed1,
                              input logic esus, input logic eflag);
        logic [19:0] a, e;
        a = {fifo_wr, fifo_wr[0] ? d0 : 8'h00, fifo_wr[1] ? d1 : 8'h00, sus, flag};
        e = {ewr, ewr[0] ? ed0 : 8'h00, ewr[1] ? ed1 : 8'h00, esus, eflag};
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (wr,d0,d1,sus,flag)", req, a, e);
        end
    endtask

    task automatic expect_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       esus;
        logic [7:0] m;
        logic       mo, mn;

        // R1: reset state
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 2'b00, 8'h0, 8'h0, 1'b0, 1'b0);
        expect_bit("R1 irq", irq, 1'b0);
        rst_n = 1'b1;

        // R2: off mode passes every character
        mode = 2'b00;
        for (int c = 0; c < 256; c++) begin
            send(8'(c));
            expect_out("R2 passthrough", 2'b01, 8'(c), 8'h0, 1'b0, 1'b0);
        end

        // R3 R4 R5: single-mode sweep under every word length
        mode = 2'b01;
        esus = 1'b0;
        for (int wl = 0; wl < 4; wl++) begin
            wlen = 2'(wl);
            m = 8'hFF >> (3 - wl);
            for (int c = 0; c < 256; c++) begin
                mo = (((8'(c) ^ xoff1) & m) == 8'h00);
                mn = (((8'(c) ^ xon1) & m) == 8'h00);
                send(8'(c));
                if (mo) begin
                    esus = 1'b1;
                    expect_out("R4 stop match", 2'b00, 8'h0, 8'h0, esus, 1'b0);
                end else if (mn) begin
                    esus = 1'b0;
                    expect_out("R5 go match", 2'b00, 8'h0, 8'h0, esus, 1'b0);
                end else begin
                    expect_out("R3 masked mismatch", 2'b01, 8'(c), 8'h0, esus, 1'b0);
                end
            end
        end
        wlen = 2'b11;

        // R5: stop wins when both values are equal
        send(xon1);
        xon1 = 8'h2A; xoff1 = 8'h2A;
        send(8'h2A);
        expect_out("R5 stop priority", 2'b00, 8'h0, 8'h0, 1'b1, 1'b0);
        xon1 = 8'h11; xoff1 = 8'h13;
        send(8'h11);
        expect_out("R5 resume", 2'b00, 8'h0, 8'h0, 1'b0, 1'b0);

        // R6 R7 R8 R9: pair mode, sweep the second character after a held stop
        mode = 2'b10;
        esus = 1'b0;
        for (int c = 0; c < 256; c++) begin
            send(8'h13);
            expect_out("R6 first held", 2'b00, 8'h0, 8'h0, esus, 1'b0);
            send(8'(c));
            if (8'(c) == 8'h19) begin
                expect_out("R6 pair stop", 2'b00, 8'h0, 8'h0, 1'b1, 1'b0);
                send(8'h11);
                expect_out("R7 go held", 2'b00, 8'h0, 8'h0, 1'b1, 1'b0);
                send(8'h17);
                expect_out("R7 pair go", 2'b00, 8'h0, 8'h0, 1'b0, 1'b0);
            end else if (8'(c) == 8'h13 || 8'(c) == 8'h11) begin
                expect_out("R9 rehold", 2'b01, 8'h13, 8'h0, esus, 1'b0);
                send(8'h00);
                expect_out("R9 flush new hold", 2'b11, 8'(c), 8'h00, esus, 1'b0);
            end else begin
                expect_out("R8 broken pair", 2'b11, 8'h13, 8'(c), esus, 1'b0);
            end
        end

        // R10: flag, interrupt and clear
        mode = 2'b01;
        flag_en = 1'b1;
        send(8'h13);
        expect_out("R10 flag set", 2'b00, 8'h0, 8'h0, 1'b1, 1'b1);
        expect_bit("R10 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        expect_bit("R10 irq raised", irq, 1'b1);
        send(8'h11);
        expect_out("R10 go clears flag", 2'b00, 8'h0, 8'h0, 1'b0, 1'b0);
        expect_bit("R10 irq low", irq, 1'b0);
        send(8'h13);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        expect_out("R10 clear input", 2'b00, 8'h0, 8'h0, 1'b1, 1'b0);
        @(negedge clk);
        flag_clr = 1'b1; rx_char = 8'h13; rx_valid = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; rx_valid = 1'b0;
        expect_out("R10 set beats clear", 2'b00, 8'h0, 8'h0, 1'b1, 1'b1);
        flag_en = 1'b0;
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        send(8'h13);
        expect_out("R10 disabled flag", 2'b00, 8'h0, 8'h0, 1'b1, 1'b0);

        // R11: marker mode
        mode = 2'b11;
        flag_en = 1'b1;
        irq_en = 1'b0;
        send(8'h19);
        expect_out("R11 marker stored", 2'b01, 8'h19, 8'h0, 1'b0, 1'b1);
        send(8'h21);
        expect_out("R11 plain stored", 2'b01, 8'h21, 8'h0, 1'b0, 1'b1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        send(8'h13);
        expect_out("R11 stop1 not marker", 2'b01, 8'h13, 8'h0, 1'b0, 1'b0);

        // R12: leaving pair mode releases pause and the held character
        flag_en = 1'b0;
        mode = 2'b10;
        send(8'h13);
        send(8'h19);
        expect_out("R12 paused", 2'b00, 8'h0, 8'h0, 1'b1, 1'b0);
        send(8'h13);
        expect_out("R12 held", 2'b00, 8'h0, 8'h0, 1'b1, 1'b0);
        mode = 2'b00;
        @(negedge clk);
        expect_out("R12 release", 2'b01, 8'h13, 8'h0, 1'b0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule